// File: doc/BRIEF.md
# Prescaled Interval Timer Bank

The block holds four interval timers that count down together from one shared tick. A prescaler runs from the bus clock and produces a single-cycle strobe on every eighth clock. Each timer moves its current count by one only on that strobe. When a running timer is at zero on a strobe, it loads its base count again and latches a pending interrupt request. The request carries that timer's vector, priority and processor destination to a downstream interrupt controller. The result is a periodic interrupt every (base + 1) × 8 bus clocks.

Software reaches the timers through a flat register port. The address is `{timer index, register select}`, with the select in the two low bits. Writes take effect at the clock edge. Reads are combinational from the registered state, so they are valid within the same cycle. Each timer has its own acknowledge input, which the interrupt controller uses to clear that timer's pending request.

Top module: `tmr_bank`

## Requirements
- R1: After reset, every timer has current count 0 and base value 0 with the hold bit (bit 31 of the base register) set. Each timer also has vector 0, priority 0, the mask bit (bit 31 of the vector/priority register) set, destination 0, and no pending request. `irq_req` is all zero.
- R2: The prescaler emits its strobe on one clock in every eight, never on two clocks in a row. A current count changes only on a strobe cycle or on a base-register write.
- R3: While the hold bit is set, the timer's current count does not change. A base-register write (select 1) with bit 31 = 0 to a held timer copies the new base (bits CNT_W-1:0) into the current count and starts counting.
- R4: A running timer decrements by one on each strobe. On a strobe with the count at zero, it reloads the base value and sets its pending request. Consecutive expiries are therefore (base + 1) × 8 clocks apart.
- R5: The current-count register (select 0) is read-only: writes to it are ignored. A read of any register returns its value in the same cycle as the address.
- R6: The vector/priority register (select 2) holds the vector in bits 7:0 and the priority in bits 19:16. The destination register (select 3) holds one bit per processor in its low bits. These values appear on `irq_vector`, `irq_prio` and `irq_dest` at the timer's slice.
- R7: Bit 30 of the vector/priority register reads as 1 while the timer's request is pending. `irq_req` for a timer is 1 only when that request is pending, the mask bit is clear and the priority is nonzero.
- R8: A high `irq_ack` bit clears that timer's pending request at the next edge. An expiry in the same cycle as the acknowledge keeps the request pending.
- R9: A base write with bit 31 = 0 to a running timer leaves the current count unchanged. The new base is used at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 4 | {timer index[1:0], register select[1:0]} |
| reg_wr | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_ack | input | 4 | Per-timer acknowledge, clears pending |
| irq_req | output | 4 | Per-timer interrupt request |
| irq_vector | output | 32 | 8-bit vector per timer, timer i at [8i+7:8i] |
| irq_prio | output | 16 | 4-bit priority per timer, timer i at [4i+3:4i] |
| irq_dest | output | 8 | Destination mask per timer, timer i at [2i+1:2i] |

## Verification
Every timer runs with every base value from 0 to 4. The bench measures the clock distance between successive expiries and reads the current count after each strobe. This separates a wrong prescale ratio from an off-by-one in the reload, and it shows the countdown order. Held timers and writes to the read-only count show that nothing moves without a strobe and a cleared hold bit. The mask, zero-priority and acknowledge patterns separate the latched pending state, which is visible through the activity bit, from the gated request output. A base change on a running timer shows that the current count is left alone until the next reload.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int DATA_W    = 32;
    localparam int HOLD_BIT  = 31;
    localparam int MASK_BIT  = 31;
    localparam int ACT_BIT   = 30;
    localparam int VEC_LSB   = 0;
    localparam int PRIO_LSB  = 16;

    typedef enum logic [1:0] {
        SEL_CUR  = 2'd0,
        SEL_BASE = 2'd1,
        SEL_VP   = 2'd2,
        SEL_DST  = 2'd3
    } tmr_sel_e;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    output logic stb
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] ph;
    } ps_t;

    ps_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.ph == LAST) s_d.ph = '0;
        else                s_d.ph = s_q.ph + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stb = (s_q.ph == LAST);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int NUM_CPU = 2,
    parameter int VEC_W   = 8,
    parameter int PRIO_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stb,
    input  logic               wr_base,
    input  logic               wr_vp,
    input  logic               wr_dst,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               ack,
    output logic [CNT_W-1:0]   cnt,
    output logic [CNT_W-1:0]   base,
    output logic               hold,
    output logic               pend,
    output logic [VEC_W-1:0]   vec,
    output logic [PRIO_W-1:0]  prio,
    output logic               mask,
    output logic [NUM_CPU-1:0] dest
);
    typedef struct packed {
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   base;
        logic               hold;
        logic               pend;
        logic [VEC_W-1:0]   vec;
        logic [PRIO_W-1:0]  prio;
        logic               mask;
        logic [NUM_CPU-1:0] dest;
    } st_t;

    st_t s_d, s_q;
    logic start, tick, expire;

    assign start  = wr_base && s_q.hold && !wdata[HOLD_BIT];
    assign tick   = !s_q.hold && stb;
    assign expire = tick && (s_q.cnt == '0);

    always_comb begin
        s_d = s_q;
        if (wr_base) begin
            s_d.base = wdata[CNT_W-1:0];
            s_d.hold = wdata[HOLD_BIT];
        end
        if (start)       s_d.cnt = wdata[CNT_W-1:0];
        else if (expire) s_d.cnt = s_q.base;
        else if (tick)   s_d.cnt = s_q.cnt - 1'b1;
        if (ack)    s_d.pend = 1'b0;
        if (expire) s_d.pend = 1'b1;
        if (wr_vp) begin
            s_d.vec  = wdata[VEC_LSB +: VEC_W];
            s_d.prio = wdata[PRIO_LSB +: PRIO_W];
            s_d.mask = wdata[MASK_BIT];
        end
        if (wr_dst) s_d.dest = wdata[NUM_CPU-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.hold <= 1'b1;
            s_q.mask <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign cnt  = s_q.cnt;
    assign base = s_q.base;
    assign hold = s_q.hold;
    assign pend = s_q.pend;
    assign vec  = s_q.vec;
    assign prio = s_q.prio;
    assign mask = s_q.mask;
    assign dest = s_q.dest;
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int CNT_W   = 16,
    parameter int NUM_CPU = 2,
    parameter int DIV     = 8,
    parameter int VEC_W   = 8,
    parameter int PRIO_W  = 4,
    localparam int IDX_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1,
    localparam int ADDR_W = IDX_W + 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic                        reg_wr,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    input  logic [NUM_TMR-1:0]          irq_ack,
    output logic [NUM_TMR-1:0]          irq_req,
    output logic [NUM_TMR*VEC_W-1:0]    irq_vector,
    output logic [NUM_TMR*PRIO_W-1:0]   irq_prio,
    output logic [NUM_TMR*NUM_CPU-1:0]  irq_dest
);
    logic                 pre_stb;
    logic [IDX_W-1:0]     idx;
    tmr_sel_e             sel;

    logic [CNT_W-1:0]     cnt_a  [NUM_TMR];
    logic [CNT_W-1:0]     base_a [NUM_TMR];
    logic [VEC_W-1:0]     vec_a  [NUM_TMR];
    logic [PRIO_W-1:0]    prio_a [NUM_TMR];
    logic [NUM_CPU-1:0]   dest_a [NUM_TMR];
    logic [NUM_TMR-1:0]   hold_v, pend_v, mask_v;
    logic [NUM_TMR-1:0]   wr_base_v, wr_vp_v, wr_dst_v;
    logic [NUM_TMR*CNT_W-1:0] cnt_flat, base_flat;

    assign idx = reg_addr[ADDR_W-1:2];
    assign sel = tmr_sel_e'(reg_addr[1:0]);

    tmr_prescale #(.DIV(DIV)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .stb   (pre_stb)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        logic hit;
        assign hit          = reg_wr && (idx == IDX_W'(i));
        assign wr_base_v[i] = hit && (sel == SEL_BASE);
        assign wr_vp_v[i]   = hit && (sel == SEL_VP);
        assign wr_dst_v[i]  = hit && (sel == SEL_DST);

        tmr_unit #(
            .CNT_W   (CNT_W),
            .NUM_CPU (NUM_CPU),
            .VEC_W   (VEC_W),
            .PRIO_W  (PRIO_W)
        ) u_unit (
            .clk     (clk),
            .rst_n   (rst_n),
            .stb     (pre_stb),
            .wr_base (wr_base_v[i]),
            .wr_vp   (wr_vp_v[i]),
            .wr_dst  (wr_dst_v[i]),
            .wdata   (reg_wdata),
            .ack     (irq_ack[i]),
            .cnt     (cnt_a[i]),
            .base    (base_a[i]),
            .hold    (hold_v[i]),
            .pend    (pend_v[i]),
            .vec     (vec_a[i]),
            .prio    (prio_a[i]),
            .mask    (mask_v[i]),
            .dest    (dest_a[i])
        );

        assign irq_req[i] = pend_v[i] && !mask_v[i] && (prio_a[i] != '0);
        assign irq_vector[i*VEC_W +: VEC_W]      = vec_a[i];
        assign irq_prio[i*PRIO_W +: PRIO_W]      = prio_a[i];
        assign irq_dest[i*NUM_CPU +: NUM_CPU]    = dest_a[i];
        assign cnt_flat[i*CNT_W +: CNT_W]        = cnt_a[i];
        assign base_flat[i*CNT_W +: CNT_W]       = base_a[i];
    end

    always_comb begin
        reg_rdata = '0;
        unique case (sel)
            SEL_CUR:  reg_rdata[CNT_W-1:0] = cnt_a[idx];
            SEL_BASE: begin
                reg_rdata[CNT_W-1:0]   = base_a[idx];
                reg_rdata[HOLD_BIT]    = hold_v[idx];
            end
            SEL_VP: begin
                reg_rdata[VEC_LSB +: VEC_W]   = vec_a[idx];
                reg_rdata[PRIO_LSB +: PRIO_W] = prio_a[idx];
                reg_rdata[ACT_BIT]            = pend_v[idx];
                reg_rdata[MASK_BIT]           = mask_v[idx];
            end
            SEL_DST:  reg_rdata[NUM_CPU-1:0] = dest_a[idx];
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/tmr_bank_chk.sv
module tmr_bank_chk #(
    parameter int NUM_TMR = 4,
    parameter int CNT_W   = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     stb,
    input logic [NUM_TMR*CNT_W-1:0] cnt_flat,
    input logic [NUM_TMR*CNT_W-1:0] base_flat,
    input logic [NUM_TMR-1:0]       hold,
    input logic [NUM_TMR-1:0]       pend,
    input logic [NUM_TMR-1:0]       base_wr,
    input logic [NUM_TMR-1:0]       ack
);
    AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        stb |=> !stb); // R2

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
        AST_CNT_ONLY_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
            (!stb && !base_wr[i]) |=> $stable(cnt_flat[i*CNT_W +: CNT_W])); // R2

        AST_HOLD_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
            (hold[i] && !base_wr[i]) |=> $stable(cnt_flat[i*CNT_W +: CNT_W])); // R3

        AST_RELOAD_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (stb && !hold[i] && cnt_flat[i*CNT_W +: CNT_W] == '0)
            |=> cnt_flat[i*CNT_W +: CNT_W] == $past(base_flat[i*CNT_W +: CNT_W])); // R4

        AST_EXPIRY_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            (stb && !hold[i] && cnt_flat[i*CNT_W +: CNT_W] == '0) |=> pend[i]); // R8

        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[i] && !stb) |=> !pend[i]); // R8
    end
endmodule

bind tmr_bank tmr_bank_chk #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (pre_stb),
    .cnt_flat  (cnt_flat),
    .base_flat (base_flat),
    .hold      (hold_v),
    .pend      (pend_v),
    .base_wr   (wr_base_v),
    .ack       (irq_ack)
);

// File: tb/tb_tmr_bank.sv
module tb_tmr_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  irq_ack = '0;
    logic [3:0]  irq_req;
    logic [31:0] irq_vector;
    logic [15:0] irq_prio;
    logic [7:0]  irq_dest;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_bank dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_ack    (irq_ack),
        .irq_req    (irq_req),
        .irq_vector (irq_vector),
        .irq_prio   (irq_prio),
        .irq_dest   (irq_dest)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int t, input int s, input logic [31:0] d);
        @(negedge clk);
        reg_addr  = {t[1:0], s[1:0]};
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input int t, input int s, output logic [31:0] d);
        reg_addr = {t[1:0], s[1:0]};
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_req(input int t, output int n);
        n = 0;
        while (irq_req[t] !== 1'b1 && n < 400) begin
            @(negedge clk);
            n++;
        end
        if (n >= 400) chk("R4 request timeout", 32'd0, 32'd1);
    endtask

    task automatic pulse_ack(input int t);
        irq_ack[t] = 1'b1;
        @(negedge clk);
        irq_ack[t] = 1'b0;
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 irq_req", {28'd0, irq_req}, 32'd0);
        for (int t = 0; t < 4; t++) begin
            rd(t, 0, d); chk("R1 current count", d, 32'd0);
            rd(t, 1, d); chk("R1 base/hold", d, 32'h8000_0000);
            rd(t, 2, d); chk("R1 vector/priority/mask", d, 32'h8000_0000);
            rd(t, 3, d); chk("R1 destination", d, 32'd0);
        end

        // R3 held timer does not count; R5 count register ignores writes
        wr(2, 1, 32'h8000_0009);
        repeat (40) @(negedge clk);
        rd(2, 0, d); chk("R3 held count", d, 32'd0);
        wr(2, 0, 32'h0000_1234);
        rd(2, 0, d); chk("R5 write to count ignored", d, 32'd0);
        rd(2, 2, d); chk("R3 no pending while held", d[30], 1'b0);

        // R4/R6 period and countdown sweep
        for (int t = 0; t < 4; t++) begin
            logic [31:0] vp;
            vp = ((t + 1) << 16) | (32'hA0 + t);
            wr(t, 2, vp);
            wr(t, 3, (t % 3) + 1);
            chk("R6 vector out", irq_vector[t*8 +: 8], 32'hA0 + t);
            chk("R6 priority out", irq_prio[t*4 +: 4], t + 1);
            chk("R6 dest out", irq_dest[t*2 +: 2], (t % 3) + 1);
            rd(t, 2, d); chk("R6 vp readback", d, vp);
            for (int b = 0; b <= 4; b++) begin
                wr(t, 1, 32'h8000_0000);
                wr(t, 1, b);
                rd(t, 0, d);
                if (b > 0) chk("R3 start loads base", (d == b || d == b - 1), 1'b1);
                wait_req(t, n);
                pulse_ack(t);
                rd(t, 2, d); chk("R8 ack clears activity", d[30], 1'b0);
                chk("R8 ack clears request", irq_req[t], 1'b0);
                n = 1;
                for (int j = 1; j <= b; j++) begin
                    while (n < 8 * j) begin @(negedge clk); n++; end
                    rd(t, 0, d); chk("R4 countdown value", d, b - j);
                end
                while (irq_req[t] !== 1'b1 && n < 400) begin @(negedge clk); n++; end
                chk("R4 expiry interval", n, (b + 1) * 8);
                rd(t, 0, d); chk("R4 reload value", d, b);
                pulse_ack(t);
            end
            wr(t, 1, 32'h8000_0000);
            pulse_ack(t);
            rd(t, 0, d);
            repeat (30) @(negedge clk);
            begin
                logic [31:0] d2;
                rd(t, 0, d2); chk("R3 hold stops count", d2, d);
            end
        end

        // R7 mask and zero priority gating
        wr(0, 2, 32'h8003_0011);
        wr(0, 1, 32'd0);
        repeat (20) @(negedge clk);
        rd(0, 2, d); chk("R7 activity while masked", d[30], 1'b1);
        chk("R7 masked request", irq_req[0], 1'b0);
        wr(0, 2, 32'h0003_0011);
        chk("R7 unmasked request", irq_req[0], 1'b1);
        wr(0, 2, 32'h0000_0011);
        chk("R7 zero priority request", irq_req[0], 1'b0);
        wr(0, 1, 32'h8000_0000);
        pulse_ack(0);
        rd(0, 2, d); chk("R8 ack clears pending", d[30], 1'b0);

        // R9 base change on running timer
        wr(1, 1, 32'd20);
        wr(1, 1, 32'd3);
        rd(1, 0, d); chk("R9 count untouched by base write", (d >= 18 && d <= 20), 1'b1);
        wait_req(1, n);
        rd(1, 0, d); chk("R9 new base at reload", d, 32'd3);
        pulse_ack(1);
        n = 1;
        while (irq_req[1] !== 1'b1 && n < 400) begin @(negedge clk); n++; end
        chk("R9 new period", n, 32'd32);
        wr(1, 1, 32'h8000_0000);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule